// File: doc/BRIEF.md
# Output-Control I2C Slave

This block is a two-wire serial slave that holds one 8-bit control byte. The byte is decoded into on/off commands and voltage-select codes for two switched regulators and two high-side switches. A host writes the byte with address byte 0x10 (7-bit device address 0001000 followed by R/W = 0). It reads the byte back with 0x11. Both lines are sampled by a fast system clock through two-flop synchronizers, so the system clock must run at least eight times the SCL rate. SCL may run at up to 400 kHz.

The serial port works only while the mode input `active_en` is high. Pulling that input low puts the block in standby. In standby the bus is ignored and the stored byte is cleared. A battery-overvoltage flag forces every decoded output off without touching the stored byte. When the flag drops, the outputs return to their programmed state with no host action.

Top module: `outctl_i2c_slave`

## Requirements
- R1: After reset, the stored byte is 0x00, every decoded output is 0, and `sda_pull` is 0.
- R2: When an address byte of 0x10 or 0x11 is clocked in MSB first, the block holds SDA low throughout the ninth (acknowledge) clock.
- R3: An address byte other than 0x10 or 0x11 gets no acknowledge. SDA then stays released and the stored byte stays unchanged until the next START.
- R4: The decoded outputs follow the stored byte one clock after it changes, using this map: bit 7 is `rail2_on`; bits 6:4 are `rail2_lvl` (000 to 111 select 3.3, 5.0, 5.5, 6.0, 7.0, 7.5, 8.0 and 10.0 V); bit 3 is `rail1_on`; bit 2 is `rail1_hi` (0 selects 5 V, 1 selects 8.5 V); bit 1 is `sw2_on`; bit 0 is `sw1_on`.
- R5: After an acknowledged 0x11 address, the block drives the stored byte MSB first, one bit per SCL clock.
- R6: While `ovp_flag` is 1, every decoded output is 0 from the next clock on, and the stored byte is kept. One clock after the flag returns to 0, the outputs show the stored byte again.
- R7: While `active_en` is 0, no byte is acknowledged, and the stored byte is cleared to 0x00 from the next clock on.
- R8: The block changes `sda_pull` only after SCL has been seen low, never while SCL stays high.
- R9: After an acknowledged write address, the block acknowledges the data byte. The stored byte takes the new value only at the end of that acknowledge clock.
- R10: A write cut off by a STOP before its acknowledge clock leaves the stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| active_en | input | 1 | 1 = active mode (bus served), 0 = standby |
| ovp_flag | input | 1 | Battery overvoltage; forces outputs off while 1 |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND value) |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| rail2_on | output | 1 | Regulator 2 enable |
| rail2_lvl | output | 3 | Regulator 2 level code |
| rail1_on | output | 1 | Regulator 1 enable |
| rail1_hi | output | 1 | Regulator 1 level select (1 = 8.5 V) |
| sw2_on | output | 1 | High-side switch 2 enable |
| sw1_on | output | 1 | High-side switch 1 enable |

## Verification
A wrong bit counter or protocol state shows up at the next acknowledge clock. The acknowledge is then missing or lands on the wrong clock, or the read-back data is shifted by one bit. A wrong stored byte reaches the decoded outputs one clock after the write commits. It also appears in the next read-back, so an error in the ignore, abort or standby paths is visible within a single follow-up transaction. The overvoltage gating is registered, so any leak through the gate is visible at the outputs one clock after the flag changes.

// File: rtl/outctl_pkg.sv
// Shared constants and types for the output-control serial slave.
// Assumes byte-wide transfers and a 7-bit device address.
package outctl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_t;

    typedef struct packed {
        logic       rail2_on;
        logic [2:0] rail2_lvl;
        logic       rail1_on;
        logic       rail1_hi;
        logic       sw2_on;
        logic       sw1_on;
    } ctrl_t;

endpackage

// File: rtl/outctl_line_sync.sv
// Synchronizes one bus line into the clk domain and keeps the previous
// synchronized value so that edge detection can be done downstream.
// Assumes the idle line level is high, so reset loads ones.
module outctl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic line_d
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    // Hold the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= 1'b1;
        else        line_d <= chain[STAGES-1];
    end

    assign line_s = chain[STAGES-1];

endmodule

// File: rtl/outctl_bus_engine.sv
// Serial protocol engine: detects START and STOP, shifts the address
// and data bits, drives the acknowledge, and serializes the read-back
// byte. It serves one byte per transfer and then ignores the bus until
// the next START. Assumes inputs are already synchronized.
module outctl_bus_engine
    import outctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_en,
    input  logic              scl_s,
    input  logic              scl_d,
    input  logic              sda_s,
    input  logic              sda_d,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              scl_rise, scl_fall, bus_start, bus_stop;

    // Bus events derived from the current and previous synchronized samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        bus_start = scl_s & scl_d & sda_d & ~sda_s;
        bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

    // Protocol state, bit counter, shift register and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (!active_en) begin
                state    <= ST_IDLE;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (bus_start) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (bus_stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            if (state == ST_WR) begin
                                state    <= ST_WR_ACK;
                                sda_pull <= 1'b1;
                            end else if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                state    <= ST_ADDR_ACK;
                                sda_pull <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (shreg[0]) begin
                                state    <= ST_RD;
                                shreg    <= rd_byte;
                                sda_pull <= ~rd_byte[BYTE_W-1];
                            end else begin
                                state    <= ST_WR;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            wr_stb   <= 1'b1;
                            state    <= ST_SKIP;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                state    <= ST_RD_ACK;
                                sda_pull <= 1'b0;
                            end else begin
                                cnt      <= cnt + 1'b1;
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_fall) state <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_byte = shreg;

endmodule

// File: rtl/outctl_regfile.sv
// Holds the control byte and produces the registered, overvoltage-gated
// decoded outputs. The byte is cleared in standby. Assumes wr_stb is a
// single-cycle pulse issued only in active mode.
module outctl_regfile
    import outctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_en,
    input  logic              ovp_flag,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] ctrl_byte,
    output ctrl_t             out_vec
);

    // Store the committed byte; standby clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_byte <= '0;
        else if (!active_en) ctrl_byte <= '0;
        else if (wr_stb)     ctrl_byte <= wr_byte;
    end

    // Register the decoded outputs, forced off during overvoltage.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_vec <= '0;
        else if (ovp_flag) out_vec <= '0;
        else               out_vec <= ctrl_t'(ctrl_byte);
    end

endmodule

// File: rtl/outctl_i2c_slave.sv
// Top level of the output-control serial slave: two line synchronizers,
// the protocol engine and the control register with output gating.
// Assumes clk runs at least 8x the SCL rate; SDA is open-drain outside.
module outctl_i2c_slave
    import outctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_en,
    input  logic       ovp_flag,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic       rail2_on,
    output logic [2:0] rail2_lvl,
    output logic       rail1_on,
    output logic       rail1_hi,
    output logic       sw2_on,
    output logic       sw1_on
);

    logic              scl_s, scl_d, sda_s, sda_d;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] ctrl_byte;
    ctrl_t             out_vec;

    outctl_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_s(scl_s), .line_d(scl_d)
    );

    outctl_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_s(sda_s), .line_d(sda_d)
    );

    outctl_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .active_en(active_en),
        .scl_s(scl_s), .scl_d(scl_d), .sda_s(sda_s), .sda_d(sda_d),
        .rd_byte(ctrl_byte), .sda_pull(sda_pull),
        .wr_stb(wr_stb), .wr_byte(wr_byte)
    );

    outctl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .active_en(active_en), .ovp_flag(ovp_flag),
        .wr_stb(wr_stb), .wr_byte(wr_byte),
        .ctrl_byte(ctrl_byte), .out_vec(out_vec)
    );

    assign rail2_on  = out_vec.rail2_on;
    assign rail2_lvl = out_vec.rail2_lvl;
    assign rail1_on  = out_vec.rail1_on;
    assign rail1_hi  = out_vec.rail1_hi;
    assign sw2_on    = out_vec.sw2_on;
    assign sw1_on    = out_vec.sw1_on;

endmodule

// File: rtl/outctl_i2c_chk.sv
// Property checker for the output-control serial slave, bound to the
// top module. Observes ports and the stored byte only.
module outctl_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active_en,
    input logic       ovp_flag,
    input logic       scl_s,
    input logic       sda_pull,
    input logic [7:0] ctrl_byte,
    input logic [7:0] out_vec
);

    // R6: overvoltage forces every decoded output off on the next clock.
    assert_ovp_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_flag |=> (out_vec == 8'h00));

    // R7: standby clears the byte and releases SDA.
    assert_standby_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active_en |=> (ctrl_byte == 8'h00 && !sda_pull));

    // R4: outputs follow the stored byte one clock later when not gated.
    assert_out_tracks_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ovp_flag) |-> (out_vec == $past(ctrl_byte)));

    // R8: SDA drive holds while SCL has been seen high.
    assert_sda_steady_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && $past(scl_s, 2) && $past(active_en)) |-> $stable(sda_pull));

endmodule

bind outctl_i2c_slave outctl_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .active_en(active_en), .ovp_flag(ovp_flag),
    .scl_s(scl_s), .sda_pull(sda_pull), .ctrl_byte(ctrl_byte),
    .out_vec(out_vec)
);

// File: tb/outctl_i2c_slave_bench.sv
`timescale 1ns/1ps
module outctl_i2c_slave_bench;

    localparam int Q = 10;   // clk cycles per quarter SCL period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       active_en = 1'b0;
    logic       ovp_flag = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       rail2_on, rail1_on, rail1_hi, sw2_on, sw1_on;
    logic [2:0] rail2_lvl;
    logic       sda_line;
    logic [7:0] obs;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] q_val[$];
    string      q_tag[$];
    event       exp_ev;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign obs = {rail2_on, rail2_lvl, rail1_on, rail1_hi, sw2_on, sw1_on};

    outctl_i2c_slave u_outctl_i2c_slave (
        .clk(clk), .rst_n(rst_n), .active_en(active_en), .ovp_flag(ovp_flag),
        .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
        .rail2_on(rail2_on), .rail2_lvl(rail2_lvl), .rail1_on(rail1_on),
        .rail1_hi(rail1_hi), .sw2_on(sw2_on), .sw1_on(sw1_on)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    // Scoreboard driver side: queue the expected output vector.
    task automatic expect_outs(input logic [7:0] exp, input string tag);
        q_val.push_back(exp);
        q_tag.push_back(tag);
        -> exp_ev;
        repeat (6) @(negedge clk);
    endtask

    // Scoreboard monitor: compares queued expectations with the outputs.
    initial begin
        forever begin
            @(exp_ev);
            repeat (2) @(negedge clk);
            while (q_val.size() > 0) begin
                logic [7:0] v;
                string t;
                v = q_val.pop_front();
                t = q_tag.pop_front();
                check8(obs, v, t);
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic xfer_bit(input logic b, output logic s);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q();
        s = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
        xfer_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, s);
            v[i] = s;
        end
        xfer_bit(1'b1, s);   // master NACK ends the read
    endtask

    task automatic write_ctrl(input logic [7:0] d, input logic exp_ack,
                              input logic [7:0] exp_out, input string tag);
        logic a;
        bus_start();
        send_byte(8'h10, a);
        check8({7'd0, a}, {7'd0, exp_ack}, {tag, " addr ack R2"});
        send_byte(d, a);
        check8({7'd0, a}, {7'd0, exp_ack}, {tag, " data ack R9"});
        bus_stop();
        expect_outs(exp_out, tag);
    endtask

    task automatic read_ctrl(input logic [7:0] exp, input string tag);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'h11, a);
        check8({7'd0, a}, 8'd1, {tag, " read addr ack R2"});
        read_byte(v);
        bus_stop();
        check8(v, exp, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check8(obs, 8'h00, "R1 outputs after reset");
        check8({7'd0, sda_pull}, 8'd0, "R1 sda released after reset");
        active_en = 1'b1;
        repeat (4) @(negedge clk);
        read_ctrl(8'h00, "R1 stored byte after reset");

        // R4/R9: basic write and decode
        write_ctrl(8'hA5, 1'b1, 8'hA5, "R4 write A5");
        read_ctrl(8'hA5, "R5 read back A5");

        // R3: wrong addresses are not acknowledged and change nothing
        bus_start();
        send_byte(8'h12, a);
        check8({7'd0, a}, 8'd0, "R3 no ack for 0x12");
        send_byte(8'h00, a);
        check8({7'd0, a}, 8'd0, "R3 data ignored after mismatch");
        bus_stop();
        expect_outs(8'hA5, "R3 outputs unchanged");
        bus_start();
        send_byte(8'h20, a);
        check8({7'd0, a}, 8'd0, "R3 no ack for 0x20");
        bus_stop();
        read_ctrl(8'hA5, "R3 byte unchanged");

        // R10: write aborted by STOP mid-byte
        bus_start();
        send_byte(8'h10, a);
        check8({7'd0, a}, 8'd1, "R10 addr ack");
        for (int i = 0; i < 4; i++) xfer_bit(1'b0, s);
        bus_stop();
        expect_outs(8'hA5, "R10 outputs unchanged after abort");
        read_ctrl(8'hA5, "R10 byte unchanged after abort");

        write_ctrl(8'h7E, 1'b1, 8'h7E, "R4 write 7E");

        // R6: overvoltage gating with automatic recovery
        ovp_flag = 1'b1;
        expect_outs(8'h00, "R6 outputs off in overvoltage");
        read_ctrl(8'h7E, "R6 byte kept in overvoltage");
        ovp_flag = 1'b0;
        expect_outs(8'h7E, "R6 outputs restored");
        ovp_flag = 1'b1;
        write_ctrl(8'hFF, 1'b1, 8'h00, "R6 write during overvoltage");
        ovp_flag = 1'b0;
        expect_outs(8'hFF, "R6 programmed value after clear");

        // R7: standby clears and blocks the bus
        active_en = 1'b0;
        expect_outs(8'h00, "R7 outputs off in standby");
        write_ctrl(8'h81, 1'b0, 8'h00, "R7 write in standby");
        active_en = 1'b1;
        repeat (4) @(negedge clk);
        read_ctrl(8'h00, "R7 byte cleared by standby");

        // R4: level code sweep for regulator 2
        for (int c = 0; c < 8; c++) begin
            logic [2:0] cc;
            cc = 3'(c);
            write_ctrl({1'b1, cc, 4'b1001}, 1'b1, {1'b1, cc, 4'b1001}, "R4 level code sweep");
        end
        write_ctrl(8'h0C, 1'b1, 8'h0C, "R4 regulator 1 high level");
        read_ctrl(8'h0C, "R5 read back 0C");

        finish_run();
    end

endmodule